// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output stage of one line in a sum-of-products logic device. A sum term from the product-term array arrives on `sum_term`. Two configuration bits decide how it reaches the pin. `cfg_mode` picks between a path through a D flip-flop and a direct combinational path. `cfg_pol` picks whether the pin is active high or active low. The output enable comes from a product term of its own. The block drives a tri-state pin model, made of a data line and an enable line, and reads the pin back on `pin_in`.

The block also returns a feedback signal to the array in both true and complement form. In registered mode the feedback is the inverted flip-flop output, so the pin level plays no part in it and a registered pin cannot serve as an input. In combinational mode the feedback is taken on the pin side of the enable buffer. When the output is disabled, the externally driven pin value is therefore what returns to the array.

Two terms are shared across cells and act on the flip-flop state, never on the pin level. An asynchronous clear forces the state to 0 the moment it is asserted. A synchronous preset forces the state to 1 at the next rising clock edge. A synchronous power-on reset `rst` also clears the state. Because these terms act on the state, the pin level that follows a clear depends on the polarity that was programmed.

Top module: `sop_out_cell`

## Requirements
- R1: With `rst` high at a rising edge, the flip-flop state becomes 0 at that edge. The pin then shows the inactive level for the programmed polarity.
- R2: In registered mode (`cfg_mode`=0), at a rising edge with `rst`, `ar_term` and `sp_term` all low, the state takes the value of `sum_term`. `pin_out` then equals the state when `cfg_pol`=1 (active high) and its inverse when `cfg_pol`=0 (active low).
- R3: In combinational mode (`cfg_mode`=1), in the same cycle and with no clock edge needed, `pin_out` equals `sum_term` when `cfg_pol`=1 and its inverse when `cfg_pol`=0.
- R4: In both modes, `pin_oe` follows `oe_term` in the same cycle.
- R5: In registered mode, `fb_true` is the inverse of the flip-flop state whatever the values of `oe_term` and `pin_in`.
- R6: In combinational mode, `fb_true` equals `pin_out` while `pin_oe`=1 and equals `pin_in` while `pin_oe`=0.
- R7: `fb_comp` is at all times the inverse of `fb_true`.
- R8: While `ar_term` is high, the state is 0 at once, before any clock edge, and it stays 0 across edges.
- R9: A high `sp_term` leaves the state unchanged until the next rising edge, and sets the state to 1 at that edge.
- R10: At an edge where `sp_term` is high, a high `ar_term` or a high `rst` wins and the state becomes 0.
- R11: After a clear, the pin reads 1 when `cfg_pol`=0 and reads 0 when `cfg_pol`=1. The state itself is 0 in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flip-flop updates on the rising edge |
| rst | input | 1 | Synchronous active-high power-on reset that clears the state |
| cfg_mode | input | 1 | 0 = registered path, 1 = combinational path |
| cfg_pol | input | 1 | 0 = active-low pin, 1 = active-high pin |
| sum_term | input | 1 | Sum term from the product-term array |
| oe_term | input | 1 | Output-enable product term for this cell |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous preset term |
| pin_in | input | 1 | Level seen on the pin, used for feedback when the output is disabled |
| pin_out | output | 1 | Data driven toward the pin |
| pin_oe | output | 1 | Drive enable for the pin |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complement form |

## Verification
The assertions check several rules at every clock edge. They check the combinational polarity path and the choice of feedback source in each mode. They check that the two feedback forms always differ. They check that the state is 0 whenever the clear term is high, and that the flip-flop captures the sum term or the preset at each edge. Other behaviour shows only in the bench's scenarios. The clear takes effect in the middle of a cycle before any edge. The preset waits for the edge and does nothing before it. The clear and the reset win over the preset. The level on the pin after a clear changes with the programmed polarity.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic {
    OC_REGISTERED    = 1'b0,
    OC_COMBINATIONAL = 1'b1
  } oc_mode_e;

  typedef enum logic {
    OC_ACT_LOW  = 1'b0,
    OC_ACT_HIGH = 1'b1
  } oc_pol_e;

endpackage

// File: rtl/oc_state_reg.sv
module oc_state_reg (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic clr_async,
  input  logic set_sync,
  output logic q
);

  // Priority: asynchronous clear, then power-on reset, then preset, then data.
  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async)     q <= 1'b0;
    else if (rst)      q <= 1'b0;
    else if (set_sync) q <= 1'b1;
    else               q <= d;
  end

  // Checker helper: records whether the clear fired at any time since the last edge.
  logic clr_seen;
  always_ff @(posedge clk or posedge clr_async) begin
    if (clr_async) clr_seen <= 1'b1;
    else           clr_seen <= 1'b0;
  end

  assert_clear_holds_R8: assert property (@(posedge clk) disable iff (rst)
    clr_async |-> (q == 1'b0));

  assert_preset_edge_R9: assert property (@(posedge clk) disable iff (rst)
    (set_sync && !clr_async) |=> (q || clr_seen));

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!set_sync && !clr_async) |=> ((q == $past(d)) || clr_seen));

endmodule

// File: rtl/oc_out_path.sv
module oc_out_path
  import oc_pkg::*;
(
  input  oc_mode_e mode,
  input  oc_pol_e  pol,
  input  logic     sum,
  input  logic     q,
  input  logic     oe,
  output logic     pin_out,
  output logic     pin_oe
);

  logic src;

  always_comb begin
    src     = (mode == OC_COMBINATIONAL) ? sum : q;
    pin_out = (pol == OC_ACT_HIGH) ? src : ~src;
    pin_oe  = oe;
  end

endmodule

// File: rtl/oc_feedback.sv
module oc_feedback
  import oc_pkg::*;
(
  input  oc_mode_e mode,
  input  logic     q,
  input  logic     pin_out,
  input  logic     pin_oe,
  input  logic     pin_in,
  output logic     fb_true,
  output logic     fb_comp
);

  logic pad_side;

  always_comb begin
    pad_side = pin_oe ? pin_out : pin_in;
    if (mode == OC_COMBINATIONAL) begin
      fb_true = pad_side;
      fb_comp = ~pad_side;
    end else begin
      fb_true = ~q;
      fb_comp = q;
    end
  end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import oc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_mode,
  input  logic cfg_pol,
  input  logic sum_term,
  input  logic oe_term,
  input  logic ar_term,
  input  logic sp_term,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_true,
  output logic fb_comp
);

  oc_mode_e mode;
  oc_pol_e  pol;
  logic     state_q;

  assign mode = oc_mode_e'(cfg_mode);
  assign pol  = oc_pol_e'(cfg_pol);

  oc_state_reg u_state (
    .clk       (clk),
    .rst       (rst),
    .d         (sum_term),
    .clr_async (ar_term),
    .set_sync  (sp_term),
    .q         (state_q)
  );

  oc_out_path u_out (
    .mode    (mode),
    .pol     (pol),
    .sum     (sum_term),
    .q       (state_q),
    .oe      (oe_term),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  oc_feedback u_fb (
    .mode    (mode),
    .q       (state_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_in  (pin_in),
    .fb_true (fb_true),
    .fb_comp (fb_comp)
  );

  assert_comb_polarity_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |-> (pin_out == (cfg_pol ? sum_term : ~sum_term)));

  assert_fb_driven_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && oe_term) |-> (fb_true == pin_out));

  assert_fb_floating_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode && !oe_term) |-> (fb_true == pin_in));

  assert_fb_registered_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |-> (fb_true == (cfg_pol ? ~pin_out : pin_out)));

  assert_fb_pair_R7: assert property (@(posedge clk) disable iff (rst)
    fb_true != fb_comp);

endmodule

// File: tb/tb_sop_out_cell.sv
module tb_sop_out_cell;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b0, cfg_pol = 1'b0, sum_term = 1'b0, oe_term = 1'b0;
  logic ar_term = 1'b0, sp_term = 1'b0, pin_in = 1'b0;
  logic pin_out, pin_oe, fb_true, fb_comp;

  always #2 clk = ~clk; // 250 MHz

  sop_out_cell dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_pol(cfg_pol),
    .sum_term(sum_term), .oe_term(oe_term), .ar_term(ar_term),
    .sp_term(sp_term), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
  );

  typedef struct {
    string      tag;
    logic [3:0] exp;
  } item_t;

  item_t scb[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;
  logic  mq    = 1'bx; // model of the flip-flop state

  function automatic logic [3:0] expect_now();
    logic po, side, ft;
    po   = cfg_mode ? (cfg_pol ? sum_term : ~sum_term) : (cfg_pol ? mq : ~mq);
    side = oe_term ? po : pin_in;
    ft   = cfg_mode ? side : ~mq;
    return {po, oe_term, ft, ~ft};
  endfunction

  // Driver: one step drives at the falling edge, then checks before and after the next rising edge.
  task automatic step(input string tag, input logic m, input logic p, input logic s,
                      input logic oe, input logic ar, input logic sp, input logic r,
                      input logic pi);
    item_t it;
    @(negedge clk);
    cfg_mode = m; cfg_pol = p; sum_term = s; oe_term = oe;
    ar_term = ar; sp_term = sp; rst = r; pin_in = pi;
    if (ar) mq = 1'b0;
    if (!$isunknown(mq)) begin
      it.tag = {tag, " pre-edge"};
      it.exp = expect_now();
      scb.push_back(it);
    end
    @(posedge clk);
    if (ar)      mq = 1'b0;
    else if (r)  mq = 1'b0;
    else if (sp) mq = 1'b1;
    else         mq = s;
    it.tag = {tag, " post-edge"};
    it.exp = expect_now();
    scb.push_back(it);
  endtask

  // Monitor: compares each queued expectation one time unit after it is pushed.
  initial begin
    item_t it;
    logic [3:0] act;
    forever begin
      wait (scb.size() > 0);
      #1;
      it  = scb.pop_front();
      act = {pin_out, pin_oe, fb_true, fb_comp};
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: {pin_out,pin_oe,fb_true,fb_comp} actual=%b expected=%b",
                 it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    //       tag          mode pol sum oe ar sp rst pin
    step("R1 reset",       0, 0, 1, 1, 0, 0, 1, 0);
    step("R1 R11 reset",   0, 0, 1, 1, 0, 0, 1, 0);
    step("R2 capture 1",   0, 1, 1, 1, 0, 0, 0, 0);
    step("R2 capture 0",   0, 1, 0, 1, 0, 0, 0, 0);
    step("R2 active low",  0, 0, 1, 1, 0, 0, 0, 0);
    step("R4 oe off",      0, 0, 1, 0, 0, 0, 0, 1);
    step("R5 pin ignored", 0, 1, 0, 0, 0, 0, 0, 1);
    step("R5 pin ignored", 0, 1, 1, 0, 0, 0, 0, 0);
    step("R3 comb high",   1, 1, 1, 1, 0, 0, 0, 0);
    step("R3 comb high",   1, 1, 0, 1, 0, 0, 0, 1);
    step("R3 comb low",    1, 0, 1, 1, 0, 0, 0, 0);
    step("R3 comb low",    1, 0, 0, 1, 0, 0, 0, 0);
    step("R6 float 1",     1, 1, 0, 0, 0, 0, 0, 1);
    step("R6 float 0",     1, 1, 1, 0, 0, 0, 0, 0);
    step("R7 R4 oe on",    1, 0, 1, 1, 0, 0, 0, 1);
    step("R2 load 0",      0, 1, 0, 1, 0, 0, 0, 0);
    step("R9 preset",      0, 1, 0, 1, 0, 1, 0, 0);
    step("R8 clear",       0, 1, 1, 1, 1, 0, 0, 0);
    step("R8 clear held",  0, 1, 1, 1, 1, 0, 0, 0);
    step("R2 reload",      0, 0, 1, 1, 0, 0, 0, 0);
    step("R10 clear>pre",  0, 0, 1, 1, 1, 1, 0, 0);
    step("R9 preset lo",   0, 0, 0, 1, 0, 1, 0, 0);
    step("R10 rst>pre",    0, 0, 0, 1, 0, 1, 1, 0);
    step("R11 high pol",   0, 1, 0, 1, 0, 0, 0, 0);
    step("R11 clear high", 0, 1, 1, 1, 1, 0, 0, 0);
    step("R11 clear low",  0, 0, 1, 1, 1, 0, 0, 0);
    step("R5 R7 fb",       0, 0, 1, 0, 0, 0, 0, 0);
    wait (scb.size() == 0);
    #3;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule